// File: doc/BRIEF.md
# Segment-Tagged Translation Cache

This block keeps a small, fully associative set of recently used address translations. Each entry is tagged with a segment number joined to a virtual page number. Each entry holds the physical page number and two access permissions, one for reads and one for writes. A lookup presents a segment, a page number, a page offset and an access type. One cycle later the block reports one of three outcomes. A hit returns the physical address, formed as the stored physical page with the request offset placed below it. A miss means that no valid entry carries the key. A protection fault means that the key is present but the access type is not permitted.

On a miss, the page-table walker outside this block finds the translation and presents it on the fill port. The fill goes into an entry chosen by a fixed rule. If an entry already carries the same key, that entry is rewritten. Otherwise the lowest-numbered empty entry is used. When every entry is valid, a round-robin pointer picks the entry to replace. A flush input, used on a context switch, invalidates the whole array in one cycle.

Top module: `seg_xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so the first lookup of any key reports a miss, and rsp_valid is low while reset is held.
- R2: An entry matches only when both its segment and its page number equal the request; the same page number under another segment, or another page number under the same segment, misses.
- R3: A lookup presented on lk_valid in cycle t is answered with rsp_valid in cycle t+1; on a hit, rsp_paddr equals the stored physical page in the upper bits concatenated with lk_off in the lower OFF_W bits.
- R4: When no valid entry carries the key, the response is a miss and rsp_paddr is zero.
- R5: A matching entry whose read permission is clear answers a read (lk_write=0) with a fault. A matching entry whose write permission is clear answers a write (lk_write=1) with a fault. A fault is never also reported as a hit or a miss, and rsp_paddr is zero.
- R6: Every response raises exactly one of rsp_hit, rsp_miss and rsp_fault, and rsp_valid never rises without a lookup in the previous cycle.
- R7: A fill whose key is not present uses an invalid entry while one exists, so up to ENTRIES distinct keys can be installed without any of them being lost.
- R8: When all entries are valid, successive fills of new keys replace entries in round-robin index order starting at entry 0 after a flush; with empty-first filling, the first such fill evicts the oldest installed key, and the next fill evicts the second oldest.
- R9: A fill whose key is already present rewrites that entry in place (new page and permissions) and evicts no other entry.
- R10: Asserting flush for one cycle invalidates every entry, so lookups starting in the next cycle miss. The flush also returns the replacement pointer to entry 0.
- R11: A fill presented in the same cycle as a flush is dropped, so its key misses afterwards.
- R12: A lookup in the same cycle as a fill of its key sees the contents from before the fill and misses; the next lookup of that key hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request strobe |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| lk_seg | input | SEG_W | Request segment number |
| lk_vpn | input | VPN_W | Request virtual page number |
| lk_off | input | OFF_W | Request page offset |
| fill_valid | input | 1 | Install strobe from the table walker |
| fill_seg | input | SEG_W | Segment of the translation to install |
| fill_vpn | input | VPN_W | Virtual page of the translation to install |
| fill_ppn | input | PPN_W | Physical page to install |
| fill_rd | input | 1 | Read permission of the installed entry |
| fill_wr | input | 1 | Write permission of the installed entry |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No valid entry for the key |
| rsp_fault | output | 1 | Entry found, access not permitted |
| rsp_paddr | output | PPN_W+OFF_W | Physical address on a hit, else zero |

## Verification
Lookups are tried with keys that share a page number but differ in segment, and with keys that share a segment but differ in page number. This separates a full-key compare from a partial one. Read and write accesses go to entries with only one permission set, so a swapped or ignored permission bit shows up as the wrong outcome. The array is filled to capacity and then overfilled twice, which shows whether empty entries are used first and whether eviction follows the round-robin order. Flush is applied alone and together with a fill, and a fill is applied together with a lookup of the same key, to pin down same-cycle ordering.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

   typedef enum logic [1:0] {
      OUTC_MISS  = 2'd0,
      OUTC_HIT   = 2'd1,
      OUTC_FAULT = 2'd2
   } outcome_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/seg_xlat_store.sv
module seg_xlat_store #(
   parameter int N     = 16,
   parameter int TAG_W = 12,
   parameter int PPN_W = 12,
   localparam int IDX_W = seg_xlat_pkg::idx_width(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic             wr_rd,
   input  logic             wr_wr,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [TAG_W-1:0] fl_tag,
   output logic [N-1:0]     lk_match,
   output logic [N-1:0]     fl_match,
   output logic [N-1:0]     valid_vec,
   output logic [PPN_W-1:0] sel_ppn,
   output logic             sel_rd,
   output logic             sel_wr
);

   logic [N-1:0][PPN_W-1:0] ppn_flat;
   logic [N-1:0]            rd_flat;
   logic [N-1:0]            wr_flat;

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [PPN_W-1:0] ppn_q;
      logic             rd_q;
      logic             wr_q;
      logic             sel_here;

      assign sel_here = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            v_q <= 1'b0;
         end else if (sel_here) begin
            v_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q <= '0;
            ppn_q <= '0;
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
         end else if (sel_here && !flush) begin
            tag_q <= wr_tag;
            ppn_q <= wr_ppn;
            rd_q  <= wr_rd;
            wr_q  <= wr_wr;
         end
      end

      assign lk_match[i]  = v_q && (tag_q == lk_tag);
      assign fl_match[i]  = v_q && (tag_q == fl_tag);
      assign valid_vec[i] = v_q;
      assign ppn_flat[i]  = ppn_q;
      assign rd_flat[i]   = rd_q;
      assign wr_flat[i]   = wr_q;
   end

   always_comb begin
      sel_ppn = '0;
      sel_rd  = 1'b0;
      sel_wr  = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (lk_match[i]) begin
            sel_ppn = sel_ppn | ppn_flat[i];
            sel_rd  = sel_rd  | rd_flat[i];
            sel_wr  = sel_wr  | wr_flat[i];
         end
      end
   end

   // R2: the victim rule keeps keys unique, so a lookup matches at most one entry
   p_unique_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));

   // R10: one flush cycle empties the array
   p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_vec == '0));

   // R9: an accepted write leaves its target entry valid
   p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> valid_vec[$past(wr_idx)]);

endmodule

// File: rtl/seg_xlat_victim.sv
module seg_xlat_victim #(
   parameter int N = 16,
   localparam int IDX_W = seg_xlat_pkg::idx_width(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             commit,
   input  logic [N-1:0]     valid_vec,
   input  logic [N-1:0]     key_match,
   output logic [IDX_W-1:0] vic_idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] match_idx;
   logic [IDX_W-1:0] free_idx;
   logic             any_match;
   logic             any_free;
   logic             advance;

   assign any_match = |key_match;
   assign any_free  = ~&valid_vec;

   always_comb begin
      match_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (key_match[i]) match_idx = IDX_W'(i);
      end
   end

   // downward scan so the last assignment wins with the lowest empty index
   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_vec[i]) free_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (any_match)     vic_idx = match_idx;
      else if (any_free) vic_idx = free_idx;
      else               vic_idx = ptr_q;
   end

   assign advance = commit && !any_match && !any_free;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         ptr_q <= '0;
      end else if (advance) begin
         ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   end

   // R7: a fresh key never displaces a valid entry while an empty one exists
   p_empty_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !any_match && any_free) |-> !valid_vec[vic_idx]);

   // R9: a present key is rewritten where it already lives
   p_rewrite_in_place_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && any_match) |-> key_match[vic_idx]);

   // R8: a replacing fill moves the pointer on
   p_rr_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !flush) |=> (ptr_q != $past(ptr_q)));

endmodule

// File: rtl/seg_xlat_cache.sv
module seg_xlat_cache #(
   parameter int ENTRIES = 16,
   parameter int SEG_W   = 4,
   parameter int VPN_W   = 8,
   parameter int OFF_W   = 12,
   parameter int PPN_W   = 12,
   parameter bit RSP_REG = 1'b1,
   localparam int TAG_W = SEG_W + VPN_W,
   localparam int PA_W  = PPN_W + OFF_W,
   localparam int IDX_W = seg_xlat_pkg::idx_width(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             lk_valid,
   input  logic             lk_write,
   input  logic [SEG_W-1:0] lk_seg,
   input  logic [VPN_W-1:0] lk_vpn,
   input  logic [OFF_W-1:0] lk_off,
   input  logic             fill_valid,
   input  logic [SEG_W-1:0] fill_seg,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_rd,
   input  logic             fill_wr,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_fault,
   output logic [PA_W-1:0]  rsp_paddr
);
   import seg_xlat_pkg::*;

   if (ENTRIES < 2)                  begin : g_chk_n   $error("ENTRIES must be at least 2"); end
   if (SEG_W < 1 || VPN_W < 1)       begin : g_chk_k   $error("key fields need width");      end
   if (OFF_W < 1 || PPN_W < 1)       begin : g_chk_a   $error("address fields need width");  end

   logic [TAG_W-1:0]   lk_tag;
   logic [TAG_W-1:0]   fl_tag;
   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] fl_match;
   logic [ENTRIES-1:0] valid_vec;
   logic [PPN_W-1:0]   sel_ppn;
   logic               sel_rd;
   logic               sel_wr;
   logic [IDX_W-1:0]   vic_idx;
   logic               commit;

   assign lk_tag = {lk_seg, lk_vpn};
   assign fl_tag = {fill_seg, fill_vpn};
   assign commit = fill_valid && !flush;

   seg_xlat_store #(.N(ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .wr_en     (commit),
      .wr_idx    (vic_idx),
      .wr_tag    (fl_tag),
      .wr_ppn    (fill_ppn),
      .wr_rd     (fill_rd),
      .wr_wr     (fill_wr),
      .lk_tag    (lk_tag),
      .fl_tag    (fl_tag),
      .lk_match  (lk_match),
      .fl_match  (fl_match),
      .valid_vec (valid_vec),
      .sel_ppn   (sel_ppn),
      .sel_rd    (sel_rd),
      .sel_wr    (sel_wr)
   );

   seg_xlat_victim #(.N(ENTRIES)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .commit    (commit),
      .valid_vec (valid_vec),
      .key_match (fl_match),
      .vic_idx   (vic_idx)
   );

   outcome_e          outc;
   logic [PA_W-1:0]   pa_c;
   logic              permitted;

   assign permitted = lk_write ? sel_wr : sel_rd;

   always_comb begin
      if (!(|lk_match))  outc = OUTC_MISS;
      else if (permitted) outc = OUTC_HIT;
      else                outc = OUTC_FAULT;
   end

   assign pa_c = (outc == OUTC_HIT) ? {sel_ppn, lk_off} : '0;

   if (RSP_REG) begin : g_rsp_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
         end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (outc == OUTC_HIT);
            rsp_miss  <= lk_valid && (outc == OUTC_MISS);
            rsp_fault <= lk_valid && (outc == OUTC_FAULT);
            rsp_paddr <= lk_valid ? pa_c : '0;
         end
      end

      // R3: the answer comes exactly one cycle after the request
      p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
         lk_valid |=> rsp_valid);

      // R6: no response without a request
      p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !lk_valid |=> !rsp_valid);
   end else begin : g_rsp_comb
      assign rsp_valid = lk_valid;
      assign rsp_hit   = lk_valid && (outc == OUTC_HIT);
      assign rsp_miss  = lk_valid && (outc == OUTC_MISS);
      assign rsp_fault = lk_valid && (outc == OUTC_FAULT);
      assign rsp_paddr = lk_valid ? pa_c : '0;
   end

   // R6: each response carries exactly one outcome
   p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

   // R4: no address leaks out on a miss or a fault
   p_paddr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));

endmodule

// File: tb/tb_seg_xlat_cache.sv
`timescale 1ns/1ps
module tb_seg_xlat_cache;

   localparam int KMISS = 0;
   localparam int KHIT  = 1;
   localparam int KFLT  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        lk_valid = 1'b0;
   logic        lk_write = 1'b0;
   logic [3:0]  lk_seg = '0;
   logic [7:0]  lk_vpn = '0;
   logic [11:0] lk_off = '0;
   logic        fill_valid = 1'b0;
   logic [3:0]  fill_seg = '0;
   logic [7:0]  fill_vpn = '0;
   logic [11:0] fill_ppn = '0;
   logic        fill_rd = 1'b0;
   logic        fill_wr = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
   logic [23:0] rsp_paddr;

   int tests = 0;
   int fails = 0;

   typedef struct {
      int          kind;
      logic [23:0] pa;
      string       req;
   } exp_t;
   exp_t q[$];

   always #2 clk = ~clk;

   seg_xlat_cache dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_valid(lk_valid), .lk_write(lk_write), .lk_seg(lk_seg), .lk_vpn(lk_vpn), .lk_off(lk_off),
      .fill_valid(fill_valid), .fill_seg(fill_seg), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_rd(fill_rd), .fill_wr(fill_wr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr)
   );

   // monitor: pops one expectation per response (R3, R6)
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         tests++;
         if (q.size() == 0) begin
            fails++;
            $display("FAIL R6 response without request: actual rsp_valid=1 expected 0");
         end else begin
            exp_t e;
            int   got;
            e = q.pop_front();
            if ({rsp_hit, rsp_miss, rsp_fault} == 3'b100)      got = KHIT;
            else if ({rsp_hit, rsp_miss, rsp_fault} == 3'b010) got = KMISS;
            else if ({rsp_hit, rsp_miss, rsp_fault} == 3'b001) got = KFLT;
            else                                               got = -1;
            if (got != e.kind || rsp_paddr !== e.pa) begin
               fails++;
               $display("FAIL %s: actual kind=%0d pa=%06h expected kind=%0d pa=%06h",
                        e.req, got, rsp_paddr, e.kind, e.pa);
            end
         end
      end
   end

   task automatic look(input logic [3:0] s, input logic [7:0] v, input logic [11:0] o,
                       input logic w, input int k, input logic [11:0] p, input string r);
      exp_t e;
      e.kind = k;
      e.pa   = (k == KHIT) ? {p, o} : 24'h0;
      e.req  = r;
      q.push_back(e);
      lk_valid = 1'b1; lk_write = w; lk_seg = s; lk_vpn = v; lk_off = o;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic fill(input logic [3:0] s, input logic [7:0] v, input logic [11:0] p,
                       input logic r, input logic w);
      fill_valid = 1'b1; fill_seg = s; fill_vpn = v; fill_ppn = p; fill_rd = r; fill_wr = w;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      tests++;
      if (rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset: actual rsp_valid=%b expected 0", rsp_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);

      look(4'h1, 8'h05, 12'h123, 1'b0, KMISS, 12'h0, "R1 empty after reset");

      // R12: fill and lookup of the same key in one cycle
      begin
         exp_t e;
         e.kind = KMISS; e.pa = 24'h0; e.req = "R12 same-cycle lookup sees old contents";
         q.push_back(e);
         lk_valid = 1'b1; lk_write = 1'b0; lk_seg = 4'h1; lk_vpn = 8'h05; lk_off = 12'h123;
         fill_valid = 1'b1; fill_seg = 4'h1; fill_vpn = 8'h05; fill_ppn = 12'h0AB;
         fill_rd = 1'b1; fill_wr = 1'b1;
         @(negedge clk);
         lk_valid = 1'b0; fill_valid = 1'b0;
      end
      look(4'h1, 8'h05, 12'h123, 1'b0, KHIT, 12'h0AB, "R12 next lookup hits");
      look(4'h1, 8'h05, 12'hFFF, 1'b1, KHIT, 12'h0AB, "R3 write hit with offset");
      look(4'h2, 8'h05, 12'h010, 1'b0, KMISS, 12'h0, "R2 other segment misses");
      look(4'h1, 8'h06, 12'h010, 1'b0, KMISS, 12'h0, "R2 other page misses");

      // R5: single-permission entries
      fill(4'h3, 8'h07, 12'h222, 1'b1, 1'b0);
      fill(4'h3, 8'h08, 12'h333, 1'b0, 1'b1);
      look(4'h3, 8'h07, 12'h004, 1'b0, KHIT, 12'h222, "R5 read allowed");
      look(4'h3, 8'h07, 12'h004, 1'b1, KFLT, 12'h0, "R5 write forbidden");
      look(4'h3, 8'h08, 12'h004, 1'b0, KFLT, 12'h0, "R5 read forbidden");
      look(4'h3, 8'h08, 12'h004, 1'b1, KHIT, 12'h333, "R5 write allowed");

      // R9: rewrite in place
      fill(4'h1, 8'h05, 12'h0CD, 1'b1, 1'b0);
      look(4'h1, 8'h05, 12'h055, 1'b0, KHIT, 12'h0CD, "R9 rewritten page");
      look(4'h1, 8'h05, 12'h055, 1'b1, KFLT, 12'h0, "R9 rewritten permissions");
      look(4'h3, 8'h07, 12'h001, 1'b0, KHIT, 12'h222, "R9 neighbour kept");
      look(4'h3, 8'h08, 12'h001, 1'b1, KHIT, 12'h333, "R9 neighbour kept");

      // R10: flush
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      look(4'h1, 8'h05, 12'h0, 1'b0, KMISS, 12'h0, "R10 flushed");
      look(4'h3, 8'h07, 12'h0, 1'b0, KMISS, 12'h0, "R10 flushed");
      look(4'h3, 8'h08, 12'h0, 1'b1, KMISS, 12'h0, "R10 flushed");

      // R11: fill during flush dropped
      flush = 1'b1;
      fill_valid = 1'b1; fill_seg = 4'h4; fill_vpn = 8'h01; fill_ppn = 12'h444;
      fill_rd = 1'b1; fill_wr = 1'b1;
      @(negedge clk);
      flush = 1'b0; fill_valid = 1'b0;
      look(4'h4, 8'h01, 12'h0, 1'b0, KMISS, 12'h0, "R11 fill with flush dropped");

      // R7: fill to capacity, nothing lost
      for (int i = 0; i < 16; i++) fill(4'h2, 8'(8'h10 + i), 12'(12'h300 + i), 1'b1, 1'b1);
      for (int i = 0; i < 16; i++)
         look(4'h2, 8'(8'h10 + i), 12'(i), 1'b0, KHIT, 12'(12'h300 + i), "R7 all installed kept");

      // R8: round-robin eviction
      fill(4'h2, 8'h40, 12'h540, 1'b1, 1'b1);
      look(4'h2, 8'h10, 12'h0, 1'b0, KMISS, 12'h0, "R8 oldest evicted");
      look(4'h2, 8'h11, 12'h7, 1'b0, KHIT, 12'h301, "R8 second kept");
      look(4'h2, 8'h40, 12'h7, 1'b0, KHIT, 12'h540, "R8 new key present");
      fill(4'h2, 8'h41, 12'h541, 1'b1, 1'b1);
      look(4'h2, 8'h11, 12'h0, 1'b0, KMISS, 12'h0, "R8 second evicted next");
      look(4'h2, 8'h12, 12'h9, 1'b0, KHIT, 12'h302, "R8 third kept");
      look(4'h2, 8'h40, 12'h9, 1'b0, KHIT, 12'h540, "R8 first replacement kept");

      repeat (3) @(negedge clk);
      tests++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R3 missing responses: actual %0d pending expected 0", q.size());
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule